// File: doc/BRIEF.md
# MSI Doorbell Status Bank

This block collects message-signalled interrupts. An endpoint writes a 32-bit word to a single doorbell location. The block decodes that word into two parts: a register number, and a bit inside that register. It then marks the bit as pending in a small bank of status registers. Each status register has its own interrupt line. The line stays high while any pending bit is present in that register.

Software services a line by reading the matching status register over a simple 32-bit register bus. The read returns the pending word with its bytes reversed, in big-endian order. The same read clears every bit it returned. The returned bit positions map back to source numbers as follows:

- The interrupt-bit-select value is the window's top bit minus the bit position.
- The source number is that value shifted left by the register-number width, ORed with the register number.

A compile-time parameter chooses between two layouts:

- **Wide layout:** each register has a full 32-bit window, and there are 2^`IBS_SHIFT` registers.
- **Narrow layout:** `IBS_SHIFT` must be 2, giving four registers. Each register has only an 8-bit window, and each window sits in its own byte lane.

Top module: `msi_doorbell_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every status bit is zero, every `irqOut` line is low and `rdData` is zero.
- R2: A doorbell write is `wrEn` high with `wrAddr` equal to 0. For data D, it selects register D[IBS_SHIFT-1:0] and bit-select value k = D >> IBS_SHIFT. In the wide layout it sets bit 31−k of that register.
- R3: In the narrow layout, register i owns bits 24−8i through 31−8i. Bit-select value k sets bit 31−8i−k.
- R4: A doorbell write whose k lies outside the window changes no state. Outside the window means k ≥ 32 in the wide layout or k ≥ 8 in the narrow layout.
- R5: `irqOut[i]` is high exactly when register i holds a pending bit. A doorbell write raises it in the cycle after the write.
- R6: In the wide layout, register i is read at byte address 4+4i. In the narrow layout it is read at 0x10+4i. `rdData` carries the result in the cycle after `rdEn`, and it is zero in any cycle that follows a cycle with `rdEn` low.
- R7: Read data is byte-swapped as follows:
  - status bits 7:0 appear on `rdData[31:24]`
  - status bits 15:8 appear on `rdData[23:16]`
  - status bits 23:16 appear on `rdData[15:8]`
  - status bits 31:24 appear on `rdData[7:0]`
- R8: A read clears exactly the bits it returned. A doorbell write that arrives in the same cycle as a read of the same register stays pending.
- R9: A read of an unmapped or misaligned address returns zero and changes nothing. A write to any address other than 0 is ignored.
- R10: Pending bits accumulate. Successive doorbell writes to one register OR their bits together until a read clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | ADDR_W | Bus write byte address |
| wrData | input | 32 | Bus write data (doorbell word) |
| rdEn | input | 1 | Bus read strobe |
| rdAddr | input | ADDR_W | Bus read byte address |
| rdData | output | 32 | Read data, registered, big-endian |
| irqOut | output | 2^IBS_SHIFT | One interrupt line per status register |

## Verification
Every result of this block appears one clock after the rising edge that captures the access:

- A doorbell write raises its interrupt line on the next edge.
- A status read puts the swapped word on `rdData` on the next edge, and drops the line on that same edge.

The bench drives all inputs just after a falling edge. It compares the outputs with its model at the following falling edge, so each comparison falls exactly one register stage after its stimulus. The same-cycle read and write case is checked over two successive reads:

- The first read shows the old bit.
- The second read shows the surviving new bit.

// File: rtl/msi_doorbell_pkg.sv
package msi_doorbell_pkg;
  localparam int REG_IDX_W = 3;
  localparam int BIT_POS_W = 5;

  typedef struct packed {
    logic                 setEn;
    logic [REG_IDX_W-1:0] setReg;
    logic [BIT_POS_W-1:0] setPos;
    logic                 clrEn;
    logic [REG_IDX_W-1:0] clrReg;
  } msiStrobe_t;

  function automatic logic [31:0] byteSwap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_doorbell_pkg::*;
#(
  parameter int IBS_SHIFT = 3,
  parameter bit NARROW    = 1'b0,
  parameter int ADDR_W    = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output msiStrobe_t        strobe
);
  localparam int NREG = 1 << IBS_SHIFT;
  localparam int WIN  = NARROW ? 8 : 32;
  localparam int BASE = NARROW ? 16 : 4;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE + 4 * NREG);

  logic [IBS_SHIFT-1:0] regSel;
  logic [31:0]          bitSel;
  logic                 inWin;
  int                   topPos;

  always_comb begin
    regSel = wrData[IBS_SHIFT-1:0];
    bitSel = wrData >> IBS_SHIFT;
    inWin  = bitSel < 32'(WIN);
    topPos = NARROW ? (31 - 8 * int'(regSel)) : 31;

    strobe.setEn  = wrEn && (wrAddr == '0) && inWin;
    strobe.setReg = REG_IDX_W'(regSel);
    strobe.setPos = BIT_POS_W'(topPos - int'(bitSel[5:0]));

    strobe.clrEn  = rdEn && (rdAddr >= BASE_A) && (rdAddr < END_A) && (rdAddr[1:0] == 2'b00);
    strobe.clrReg = REG_IDX_W'((rdAddr - BASE_A) >> 2);
  end
endmodule

// File: rtl/msi_doorbell_datapath.sv
module msi_doorbell_datapath
  import msi_doorbell_pkg::*;
#(
  parameter int IBS_SHIFT = 3,
  parameter bit NARROW    = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  msiStrobe_t                 strobe,
  output logic [31:0]                rdData,
  output logic [(1<<IBS_SHIFT)-1:0]  irqOut
);
  localparam int NREG = 1 << IBS_SHIFT;

  logic [NREG-1:0][31:0] maskedWord;
  logic [NREG-1:0]       clrHit;
  logic [31:0]           selWord;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int LANE = (24 - 8 * i) < 0 ? 0 : (24 - 8 * i);
    localparam logic [31:0] WMASK = NARROW ? (32'h0000_00FF << LANE) : 32'hFFFF_FFFF;

    logic [31:0] statQ;
    logic [31:0] setMask;

    always_comb begin
      clrHit[i] = strobe.clrEn && (strobe.clrReg == REG_IDX_W'(i));
      setMask   = (strobe.setEn && (strobe.setReg == REG_IDX_W'(i)))
                  ? ((32'd1 << strobe.setPos) & WMASK) : '0;
    end

    always_ff @(posedge clk) begin
      if (rst) statQ <= '0;
      else     statQ <= (clrHit[i] ? '0 : statQ) | setMask;
    end

    assign maskedWord[i] = statQ & WMASK;
    assign irqOut[i]     = |maskedWord[i];
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NREG; i++)
      if (clrHit[i]) selWord = selWord | maskedWord[i];
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strobe.clrEn) rdData <= byteSwap(selWord);
    else                  rdData <= '0;
  end
endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
  import msi_doorbell_pkg::*;
#(
  parameter int IBS_SHIFT = 3,
  parameter bit NARROW    = 1'b0,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [31:0]               wrData,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [31:0]               rdData,
  output logic [(1<<IBS_SHIFT)-1:0] irqOut
);
  msiStrobe_t strobe;

  msi_doorbell_ctrl #(.IBS_SHIFT(IBS_SHIFT), .NARROW(NARROW), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe)
  );

  msi_doorbell_datapath #(.IBS_SHIFT(IBS_SHIFT), .NARROW(NARROW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/msi_doorbell_bank_chk.sv
module msi_doorbell_bank_chk #(
  parameter int IBS_SHIFT = 3,
  parameter bit NARROW    = 1'b0,
  parameter int ADDR_W    = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         wrAddr,
  input logic [31:0]               wrData,
  input logic                      rdEn,
  input logic [ADDR_W-1:0]         rdAddr,
  input logic [31:0]               rdData,
  input logic [(1<<IBS_SHIFT)-1:0] irqOut
);
  localparam int NREG = 1 << IBS_SHIFT;
  localparam int WIN  = NARROW ? 8 : 32;
  localparam int BASE = NARROW ? 16 : 4;

  logic                 dbHit;
  logic                 dbLive;
  logic                 rdMapped;
  logic [IBS_SHIFT-1:0] dbRegQ;

  assign dbHit    = wrEn && (wrAddr == '0);
  assign dbLive   = dbHit && ((wrData >> IBS_SHIFT) < 32'(WIN));
  assign rdMapped = (rdAddr >= ADDR_W'(BASE)) && (rdAddr < ADDR_W'(BASE + 4 * NREG))
                    && (rdAddr[1:0] == 2'b00);

  always_ff @(posedge clk) dbRegQ <= wrData[IBS_SHIFT-1:0];

  // R5
  db_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    dbLive |=> irqOut[dbRegQ]);

  // R6
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> (rdData == '0));

  // R9
  unmapped_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !rdMapped) |=> (rdData == '0));

  // R4
  quiet_irq_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbLive && !rdEn) |=> $stable(irqOut));

  for (genvar i = 0; i < NREG; i++) begin : g_clr
    // R8
    read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (rdEn && rdAddr == ADDR_W'(BASE + 4 * i) && !dbHit) |=> !irqOut[i]);
  end
endmodule

bind msi_doorbell_bank msi_doorbell_bank_chk #(
  .IBS_SHIFT(IBS_SHIFT), .NARROW(NARROW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/msi_doorbell_bank_tb.sv
`timescale 1ns/1ps

module msi_ref_model #(
  parameter int S      = 3,
  parameter bit NARROW = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        rdEn,
  input  logic [7:0]  rdAddr,
  output logic [31:0] expRd,
  output logic [7:0]  expIrq
);
  logic [31:0] stat [8];
  logic [31:0] v;
  longint      k;
  int          r, top, idx;
  int          nreg, win, base;

  initial begin
    nreg = 1 << S; win = NARROW ? 8 : 32; base = NARROW ? 16 : 4;
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) stat[i] = '0;
      expRd = '0;
    end else begin
      expRd = '0;
      if (rdEn && int'(rdAddr) >= base && int'(rdAddr) < base + 4 * nreg && rdAddr[1:0] == 2'b00) begin
        idx = (int'(rdAddr) - base) / 4;
        v = stat[idx];
        expRd = {v[7:0], v[15:8], v[23:16], v[31:24]};
        stat[idx] = '0;
      end
      if (wrEn && wrAddr == 8'd0) begin
        r = int'(wrData) & (nreg - 1);
        k = longint'(wrData) >> S;
        if (k < win) begin
          top = NARROW ? 31 - 8 * r : 31;
          stat[r][top - int'(k)] = 1'b1;
        end
      end
    end
    for (int i = 0; i < 8; i++) expIrq[i] = (i < nreg) && (stat[i] != 0);
  end
endmodule

module msi_doorbell_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataF, rdDataN, expRdF, expRdN;
  logic [7:0]  irqF, expIrqF, expIrqN;
  logic [3:0]  irqN;
  logic        started = 1'b0;
  int          checks = 0, failures = 0;
  string       phase = "R1";

  always #2.5 clk = ~clk;

  msi_doorbell_bank u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataF), .irqOut(irqF)
  );

  msi_doorbell_bank #(.IBS_SHIFT(2), .NARROW(1'b1)) u_dut_narrow (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataN), .irqOut(irqN)
  );

  msi_ref_model #(.S(3), .NARROW(1'b0)) u_refF (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .expRd(expRdF), .expIrq(expIrqF)
  );

  msi_ref_model #(.S(2), .NARROW(1'b1)) u_refN (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .expRd(expRdN), .expIrq(expIrqN)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (started) begin
      chk({irqF, rdDataF[23:0]} ^ 32'd0 == {expIrqF, expRdF[23:0]} ? 32'd0 : 32'd1, 32'd0,
          {phase, " wide cycle"});
      chk(rdDataF, expRdF, {phase, " wide rdData"});
      chk({28'd0, irqN}, {28'd0, expIrqN[3:0]}, {phase, " narrow irq"});
      chk(rdDataN, expRdN, {phase, " narrow rdData"});
    end
  end

  always @(posedge clk) started <= 1'b1;

  task automatic cyc(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                     input bit re, input logic [7:0] ra);
    wrEn = we; wrAddr = wa; wrData = wd; rdEn = re; rdAddr = ra;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; wrAddr = '0; rdAddr = '0; wrData = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] prevF;
    logic [3:0] prevN;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdDataF, 32'd0, "R1 rdData wide");
    chk({24'd0, irqF}, 32'd0, "R1 irq wide");
    chk({28'd0, irqN}, 32'd0, "R1 irq narrow");
    rst = 1'b0;
    @(negedge clk);
    chk({24'd0, irqF}, 32'd0, "R1 irq after release");

    phase = "R2";
    cyc(1, 8'd0, 32'd0, 0, 8'd0);
    chk({24'd0, irqF}, 32'h01, "R5 wide irq after doorbell");
    chk({28'd0, irqN}, 32'h1, "R5 narrow irq after doorbell");
    cyc(1, 8'd0, (32'd31 << 3) | 32'd5, 0, 8'd0);
    chk({31'd0, irqF[5]}, 32'd1, "R2 wide reg5 pending");
    cyc(0, 8'd0, 32'd0, 1, 8'd4);
    chk(rdDataF, 32'h0000_0080, "R7 wide reg0 k0 byte order");
    chk(rdDataN, 32'd0, "R9 narrow addr 4 unmapped");
    chk({31'd0, irqF[0]}, 32'd0, "R8 wide reg0 cleared by read");
    cyc(0, 8'd0, 32'd0, 1, 8'd24);
    chk(rdDataF, 32'h0100_0000, "R2 wide reg5 k31 bit0");

    phase = "R3";
    cyc(1, 8'd0, 32'd1, 0, 8'd0);
    cyc(0, 8'd0, 32'd0, 1, 8'h14);
    chk(rdDataN, 32'h0000_8000, "R3 narrow reg1 k0 bit23");
    cyc(1, 8'd0, (32'd7 << 2) | 32'd3, 0, 8'd0);
    cyc(0, 8'd0, 32'd0, 1, 8'h1C);
    chk(rdDataN, 32'h0100_0000, "R3 narrow reg3 k7 bit0");
    phase = "R6";
    cyc(0, 8'd0, 32'd0, 0, 8'd0);
    chk(rdDataF, 32'd0, "R6 idle rdData zero");

    // drain every register
    for (int a = 4; a <= 36; a += 4) cyc(0, 8'd0, 32'd0, 1, 8'(a));
    chk({24'd0, irqF}, 32'd0, "R6 wide all drained");
    chk({28'd0, irqN}, 32'd0, "R6 narrow all drained");

    phase = "R4";
    cyc(1, 8'd0, 32'd256, 0, 8'd0);
    chk({24'd0, irqF}, 32'd0, "R4 wide k32 dropped");
    chk({28'd0, irqN}, 32'd0, "R4 narrow k64 dropped");
    cyc(1, 8'd0, 32'hFFFF_FFFF, 0, 8'd0);
    chk({24'd0, irqF}, 32'd0, "R4 wide huge k dropped");
    cyc(1, 8'd0, 32'd32, 0, 8'd0);
    chk({28'd0, irqN}, 32'd0, "R4 narrow k8 dropped");
    chk({24'd0, irqF}, 32'h01, "R4 wide k4 accepted");
    cyc(0, 8'd0, 32'd0, 1, 8'd4);

    phase = "R8";
    cyc(1, 8'd0, 32'd2, 0, 8'd0);
    cyc(1, 8'd0, (32'd1 << 3) | 32'd2, 1, 8'd12);
    chk(rdDataF, 32'h0000_0080, "R8 read returns old bit");
    chk({31'd0, irqF[2]}, 32'd1, "R8 concurrent write kept");
    cyc(0, 8'd0, 32'd0, 1, 8'd12);
    chk(rdDataF, 32'h0000_0040, "R8 surviving bit30");

    phase = "R10";
    cyc(1, 8'd0, 32'd2, 0, 8'd0);
    cyc(1, 8'd0, 32'd6, 0, 8'd0);
    cyc(0, 8'd0, 32'd0, 1, 8'h18);
    chk(rdDataN, 32'h00E0_0000, "R10 narrow reg2 accumulated");

    phase = "R9";
    prevF = irqF; prevN = irqN;
    cyc(1, 8'd4, 32'd0, 0, 8'd0);
    chk({24'd0, irqF}, {24'd0, prevF}, "R9 wide write off doorbell ignored");
    chk({28'd0, irqN}, {28'd0, prevN}, "R9 narrow write off doorbell ignored");
    cyc(0, 8'd0, 32'd0, 1, 8'd2);
    chk(rdDataF, 32'd0, "R9 misaligned read zero");
    chk({24'd0, irqF}, {24'd0, prevF}, "R9 misaligned read no clear");

    phase = "random R2";
    for (int n = 0; n < 600; n++) begin
      automatic logic [31:0] d = ($urandom % 4 == 0) ? $urandom : ($urandom % 300);
      automatic logic [7:0]  wa = ($urandom % 5 == 0) ? 8'($urandom % 40) : 8'd0;
      cyc(($urandom % 2) == 0, wa, d, ($urandom % 3) == 0, 8'($urandom % 44));
    end
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule